// File: doc/BRIEF.md
# Shadow Instruction Prefetch Queue Tracker

This block sits beside a processor and rebuilds, from outside, the contents of the processor's small internal instruction prefetch queue. Each time the supplied fetch-complete strobe fires, the byte on the 8-bit data bus is pushed into a shadow first-in first-out store. A 2-bit queue-status code, driven by the processor on every clock, tells the block when the processor removed the opening byte of an instruction, removed a later byte of the same instruction, or threw away the whole queue.

The queue-status code describes what happened inside the processor during the clock before it appears. The block therefore registers it once and acts on it one clock later. Every removal produces a one-cycle strobe carrying the removed byte, together with a bit that marks the start of a new instruction. A trace unit or debugger can use this to find instruction boundaries without decoding the bus. Occupancy and underflow/overflow pulses show when the shadow copy has lost step with the processor.

Top module: `pq_shadow_tracker`

## Requirements
- R1: After reset, `take_valid`, `err_underflow` and `err_overflow` are 0, `fill_count` is 0, `q_empty` is 1 and `q_full` is 0.
- R2: A high `fetch_done` at a clock edge stores `fetch_byte` and raises `fill_count` by one after that edge. The count never exceeds DEPTH (4). `q_full` is 1 exactly at DEPTH and `q_empty` is 1 exactly at 0.
- R3: A `q_status` value sampled at edge N takes effect at edge N+1. For a take code (01 or 11), `take_valid` is high for the one cycle that follows edge N+1.
- R4: Bytes leave in the order they were stored.
- R5: `take_first` is 1 for a byte removed by code 01 and 0 for a byte removed by code 11.
- R6: Code 10 empties the store at the edge where it takes effect. A `fetch_done` byte presented at that same edge is discarded.
- R7: A take code that takes effect while the store is empty produces a one-cycle `err_underflow` pulse and no `take_valid`. A `fetch_done` byte at that same edge is still stored.
- R8: A `fetch_done` at an edge where the store holds DEPTH bytes and no byte is removed produces a one-cycle `err_overflow` pulse. The byte is dropped and the stored bytes are unchanged.
- R9: When a removal and a `fetch_done` coincide on a full store, there is no overflow and `fill_count` stays at DEPTH.
- R10: Code 00 removes nothing. With no `fetch_done`, the store and `fill_count` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_done | input | 1 | Code-fetch completion strobe; stores `fetch_byte` |
| fetch_byte | input | 8 | Data bus byte of the completed code fetch |
| q_status | input | 2 | Queue-status code: 00 idle, 01 first byte, 10 flush, 11 later byte |
| take_valid | output | 1 | One-cycle strobe for each byte removed |
| take_byte | output | 8 | Byte removed, valid with `take_valid` |
| take_first | output | 1 | Removed byte opens an instruction |
| fill_count | output | 3 | Number of bytes held |
| q_empty | output | 1 | Store holds no bytes |
| q_full | output | 1 | Store holds DEPTH bytes |
| err_underflow | output | 1 | Take code arrived with store empty |
| err_overflow | output | 1 | Fetch arrived with store full and nothing removed |

## Verification
The cases that are hardest to reach are the ones where a status code takes effect in the same cycle as a fetch strobe at the edges of occupancy. Examples are a flush that swallows a fetch arriving with it, or a removal on a full store that frees room for a fetch arriving with it. These cannot be lined up from the ports without accounting for the one-clock status lag. The stimulus therefore clears the store, fills it to each level from 0 to 4, and then presents every status code one cycle ahead of a fetch or no-fetch. This covers all 40 combinations of level, code and fetch, and a long pseudo-random run follows.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qs_e;

    typedef struct packed {
        logic clear;
        logic pop;
        logic push;
        logic is_first;
    } q_op_t;

endpackage

// File: rtl/pq_status_stage.sv
module pq_status_stage
    import pq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] qs_in,
    output qs_e        qs_out
);
    typedef struct packed {
        qs_e code;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.code = qs_e'(qs_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{code: QS_IDLE};
        else        st_q <= st_d;
    end

    assign qs_out = st_q.code;
endmodule

// File: rtl/pq_op_decode.sv
module pq_op_decode
    import pq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
)(
    input  qs_e            qs,
    input  logic           fetch_done,
    input  logic [CW-1:0]  count,
    output q_op_t          op,
    output logic           underflow,
    output logic           overflow
);
    logic take, flush, is_empty, is_full;

    always_comb begin
        take     = (qs == QS_FIRST) || (qs == QS_NEXT);
        flush    = (qs == QS_FLUSH);
        is_empty = (count == '0);
        is_full  = (count == CW'(DEPTH));

        op.clear    = flush;
        op.pop      = take && !is_empty;
        op.is_first = (qs == QS_FIRST);
        op.push     = fetch_done && !flush && (!is_full || op.pop);

        underflow = take && is_empty;
        overflow  = fetch_done && !flush && is_full && !op.pop;
    end
endmodule

// File: rtl/pq_byte_store.sv
module pq_byte_store
    import pq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  q_op_t             op,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     count
);
    typedef struct packed {
        logic [AW-1:0] head;
        logic [CW-1:0] count;
    } ptr_t;

    ptr_t              ptr_d, ptr_q;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     tail;

    function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a, input int b);
        int s;
        s = int'(a) + b;
        if (s >= DEPTH) s = s - DEPTH;
        return AW'(s);
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        tail = wrap_add(ptr_q.head, int'(ptr_q.count));

        if (op.clear) begin
            ptr_d.head  = '0;
            ptr_d.count = '0;
        end else begin
            if (op.pop)  ptr_d.head = wrap_add(ptr_q.head, 1);
            if (op.push) mem_d[tail] = wr_data;
            case ({op.push, op.pop})
                2'b10:   ptr_d.count = ptr_q.count + 1'b1;
                2'b01:   ptr_d.count = ptr_q.count - 1'b1;
                default: ptr_d.count = ptr_q.count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ptr_q <= ptr_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[ptr_q.head];
    assign count   = ptr_q.count;

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.count <= CW'(DEPTH));

    // R6
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op.clear |=> (ptr_q.count == '0));

    // R9
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op.push && op.pop && !op.clear) |=> (ptr_q.count == $past(ptr_q.count)));
endmodule

// File: rtl/pq_take_stage.sv
module pq_take_stage #(
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              is_first,
    input  logic [DATA_W-1:0] head_byte,
    input  logic              underflow,
    input  logic              overflow,
    output logic              take_valid,
    output logic              take_first,
    output logic [DATA_W-1:0] take_byte,
    output logic              err_underflow,
    output logic              err_overflow
);
    typedef struct packed {
        logic              valid;
        logic              first;
        logic [DATA_W-1:0] data;
        logic              uf;
        logic              of;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = pop;
        out_d.first = pop && is_first;
        if (pop) out_d.data = head_byte;
        out_d.uf    = underflow;
        out_d.of    = overflow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign take_valid    = out_q.valid;
    assign take_first    = out_q.first;
    assign take_byte     = out_q.data;
    assign err_underflow = out_q.uf;
    assign err_overflow  = out_q.of;
endmodule

// File: rtl/pq_shadow_tracker.sv
module pq_shadow_tracker
    import pq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int CW    = $clog2(DEPTH + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_done,
    input  logic [DATA_W-1:0] fetch_byte,
    input  logic [1:0]        q_status,
    output logic              take_valid,
    output logic [DATA_W-1:0] take_byte,
    output logic              take_first,
    output logic [CW-1:0]     fill_count,
    output logic              q_empty,
    output logic              q_full,
    output logic              err_underflow,
    output logic              err_overflow
);
    qs_e               qs_q;
    q_op_t             op;
    logic              uf, of;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] head_byte;

    pq_status_stage u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .qs_in  (q_status),
        .qs_out (qs_q)
    );

    pq_op_decode #(.DEPTH(DEPTH)) u_decode (
        .qs         (qs_q),
        .fetch_done (fetch_done),
        .count      (cnt),
        .op         (op),
        .underflow  (uf),
        .overflow   (of)
    );

    pq_byte_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wr_data (fetch_byte),
        .rd_data (head_byte),
        .count   (cnt)
    );

    pq_take_stage #(.DATA_W(DATA_W)) u_take (
        .clk           (clk),
        .rst_n         (rst_n),
        .pop           (op.pop),
        .is_first      (op.is_first),
        .head_byte     (head_byte),
        .underflow     (uf),
        .overflow      (of),
        .take_valid    (take_valid),
        .take_first    (take_first),
        .take_byte     (take_byte),
        .err_underflow (err_underflow),
        .err_overflow  (err_overflow)
    );

    assign fill_count = cnt;
    assign q_empty    = (cnt == '0);
    assign q_full     = (cnt == CW'(DEPTH));

    // R3
    take_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> ($past(q_status, 2) == 2'b01 || $past(q_status, 2) == 2'b11));

    // R5
    first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_first) |-> ($past(q_status, 2) == 2'b01));

    // R7
    underflow_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> !take_valid);

    // R8
    overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> q_full);

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qs_q == QS_IDLE && !fetch_done) |=> $stable(fill_count));
endmodule

// File: tb/pq_shadow_tracker_bench.sv
module pq_shadow_tracker_bench;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_done = 1'b0;
    logic [7:0] fetch_byte = '0;
    logic [1:0] q_status = '0;
    logic       take_valid, take_first, q_empty, q_full, err_underflow, err_overflow;
    logic [7:0] take_byte;
    logic [2:0] fill_count;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] mq [D];
    int         mcnt = 0;
    logic [1:0] pend = 2'b00;
    logic [7:0] seed = 8'h5a;

    always #2.5 clk = ~clk;

    pq_shadow_tracker u_pq_shadow_tracker (
        .clk(clk), .rst_n(rst_n), .fetch_done(fetch_done), .fetch_byte(fetch_byte),
        .q_status(q_status), .take_valid(take_valid), .take_byte(take_byte),
        .take_first(take_first), .fill_count(fill_count), .q_empty(q_empty),
        .q_full(q_full), .err_underflow(err_underflow), .err_overflow(err_overflow)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, step the model at the edge, compare after it.
    task automatic cyc(input bit fd, input logic [7:0] fb, input logic [1:0] qs);
        bit   ev, ef, euf, eof;
        int   eb;
        string ctag;
        fetch_done = fd; fetch_byte = fb; q_status = qs;
        @(posedge clk);
        @(negedge clk);
        ev = 0; ef = 0; euf = 0; eof = 0; eb = 0;
        ctag = "R2";
        if (pend == 2'b10) begin
            mcnt = 0;
            ctag = "R6";
        end else begin
            if (pend[0]) begin
                if (mcnt == 0) euf = 1;
                else begin
                    ev = 1; eb = int'(mq[0]); ef = (pend == 2'b01);
                    for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
                    mcnt--;
                end
            end else if (!fd) ctag = "R10";
            if (fd) begin
                if (mcnt == D) eof = 1;
                else begin
                    if (ev && mcnt == D - 1) ctag = "R9";
                    mq[mcnt] = fb; mcnt++;
                end
            end
        end
        check("R3 take_valid", int'(take_valid), int'(ev));
        if (ev) begin
            check("R4 take_byte", int'(take_byte), eb);
            check("R5 take_first", int'(take_first), int'(ef));
        end
        check({ctag, " fill_count"}, int'(fill_count), mcnt);
        check("R2 q_empty", int'(q_empty), int'(mcnt == 0));
        check("R2 q_full", int'(q_full), int'(mcnt == D));
        check("R7 err_underflow", int'(err_underflow), int'(euf));
        check("R8 err_overflow", int'(err_overflow), int'(eof));
        pend = qs;
    endtask

    function automatic logic [7:0] lfsr(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 take_valid", int'(take_valid), 0);
        check("R1 fill_count", int'(fill_count), 0);
        check("R1 q_empty", int'(q_empty), 1);
        check("R1 q_full", int'(q_full), 0);
        check("R1 err_underflow", int'(err_underflow), 0);
        check("R1 err_overflow", int'(err_overflow), 0);

        // Directed: fill, overflow, ordered drain with first flags, underflow.
        for (int i = 0; i < 5; i++) cyc(1, 8'(8'h10 + i), 2'b00);
        cyc(0, 0, 2'b01);
        for (int i = 0; i < 4; i++) cyc(0, 0, 2'b11);
        cyc(0, 0, 2'b00);
        cyc(0, 0, 2'b00);

        // Near-exhaustive: every fill level x status code x fetch.
        for (int lvl = 0; lvl <= D; lvl++) begin
            for (int code = 0; code < 4; code++) begin
                for (int f = 0; f < 2; f++) begin
                    cyc(0, 0, 2'b10);
                    cyc(0, 0, 2'b00);
                    for (int k = 0; k < lvl; k++) cyc(1, 8'(lvl * 16 + k), 2'b00);
                    cyc(0, 0, 2'(code));
                    cyc(f[0], 8'(8'hA0 + lvl * 8 + code * 2 + f), 2'b00);
                    for (int k = 0; k < D + 1; k++) cyc(0, 0, (k == 0) ? 2'b01 : 2'b11);
                    cyc(0, 0, 2'b00);
                end
            end
        end

        // Pseudo-random run.
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] qs;
            seed = lfsr(seed);
            if (seed[7:3] == 5'd0) qs = 2'b10;
            else                   qs = {seed[2], seed[1] | seed[2]} & {seed[2], seed[1] | seed[2] | seed[6]};
            cyc(seed[0] ^ seed[4], seed ^ 8'h3c, qs);
        end
        cyc(0, 0, 2'b00);
        cyc(0, 0, 2'b00);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule